// File: doc/BRIEF.md
# Read-Priority Write Deferral Buffer

This block sits between a request front end and a DRAM command scheduler. Write requests are accepted into a small age-ordered store and held there. Read requests therefore reach the memory ahead of older writes. Each incoming read address is compared with every write still held. On a match, the read is answered directly from the held data, and no read command goes downstream. This keeps read-after-write order correct even though reads overtake writes.

Held writes leave through the single downstream command port, oldest first. They leave when no read needs the port, or at any time once occupancy reaches a drain threshold. When that threshold is active, writes take priority over reads that miss. A write to an address that is already held updates that entry in place, so no second entry is used. Reads that miss are sent downstream; their data comes back from memory on a path outside this block. Reads that hit are answered on the local response port one cycle after they are accepted.

Top module: `wdefer_buf`

## Requirements
- R1: After a synchronous active-high reset the store is empty, `cmd_valid` and `rsp_valid` are 0 and `wr_ready` is 1.
- R2: An accepted write is never issued downstream in the cycle it is accepted. It appears on the command port (`cmd_we`=1) from the following cycle onward.
- R3: A read whose address matches no held write, presented while occupancy is below the drain threshold (6), is put on the command port in the same cycle with `cmd_we`=0 and `cmd_addr`=`rd_addr`, ahead of any held writes. `rd_ready` then equals `cmd_ready`.
- R4: A read whose address matches a held write is accepted in the same cycle (`rd_ready`=1) and produces no downstream read command. `rsp_valid` rises one cycle later, and `rsp_data` is the youngest held data for that address.
- R5: A write accepted in the same cycle as a read to the same address is treated as younger than that read and is not visible to it.
- R6: A write to an address already held overwrites that entry's data and allocates no new entry. The exception is when that entry leaves downstream in the same cycle; the write then takes a new entry.
- R7: Held writes are issued downstream strictly in order of allocation, oldest first, whenever no read miss is pending.
- R8: While occupancy is at or above the drain threshold (6 of 8), the command port carries the oldest write even if a read miss is pending. That read waits with `rd_ready`=0.
- R9: With all 8 entries occupied, `wr_ready` is 0.
- R10: Every read returns the data of the latest write accepted before it to the same address: from the store on a hit, or from memory on a miss.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rd_valid | input | 1 | Read request valid |
| rd_ready | output | 1 | Read request accepted this cycle |
| rd_addr | input | 16 | Read address |
| wr_valid | input | 1 | Write request valid |
| wr_ready | output | 1 | Write request can be accepted |
| wr_addr | input | 16 | Write address |
| wr_data | input | 32 | Write data |
| cmd_valid | output | 1 | Downstream command valid |
| cmd_ready | input | 1 | Downstream scheduler takes the command |
| cmd_we | output | 1 | 1 = write command, 0 = read command |
| cmd_addr | output | 16 | Command address |
| cmd_data | output | 32 | Write data of a write command, 0 for reads |
| rsp_valid | output | 1 | Locally served read data valid |
| rsp_data | output | 32 | Locally served read data |

## Verification
The assertions assume the front end holds a request stable while it is not accepted. They also assume that nothing outside the block reorders downstream commands, so memory content follows the order in which write commands leave. The stimulus changes a request only after it has been accepted or while its valid is low. It draws addresses from a small set so that hits, merges and same-cycle collisions occur often. The downstream model applies each write command at the moment it is taken and answers each read command from that state.

// File: rtl/wdb_pkg.sv
package wdb_pkg;
    parameter int ADDR_W = 16;
    parameter int DATA_W = 32;

    typedef enum logic [1:0] {
        SEL_NONE  = 2'd0,
        SEL_READ  = 2'd1,
        SEL_WRITE = 2'd2
    } cmd_sel_e;

    typedef struct packed {
        logic              vld;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] data;
    } wentry_t;
endpackage

// File: rtl/wdb_store.sv
module wdb_store
    import wdb_pkg::*;
#(
    parameter int DEPTH = 8,
    localparam int PW = $clog2(DEPTH),
    localparam int CW = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              push_en,
    input  logic [ADDR_W-1:0] push_addr,
    input  logic [DATA_W-1:0] push_data,
    input  logic              pop_en,
    input  logic [ADDR_W-1:0] look_addr,
    output logic              look_hit,
    output logic [DATA_W-1:0] look_data,
    output logic [ADDR_W-1:0] head_addr,
    output logic [DATA_W-1:0] head_data,
    output logic [CW-1:0]     count
);
    wentry_t        ent_q [DEPTH];
    logic [PW-1:0]  head_q, tail_q;
    logic [CW-1:0]  cnt_q;
    logic           mrg_hit;
    logic [PW-1:0]  mrg_idx;
    logic           new_alloc;

    // age-ordered scan: a later (younger) match overrides an earlier one
    always_comb begin
        logic [PW-1:0] idx;
        look_hit  = 1'b0;
        look_data = '0;
        for (int k = 0; k < DEPTH; k++) begin
            idx = head_q + PW'(k);
            if (ent_q[idx].vld && ent_q[idx].addr == look_addr) begin
                look_hit  = 1'b1;
                look_data = ent_q[idx].data;
            end
        end
    end

    // coalescing target; an entry leaving this cycle cannot absorb the write
    always_comb begin
        mrg_hit = 1'b0;
        mrg_idx = '0;
        for (int i = 0; i < DEPTH; i++) begin
            if (ent_q[i].vld && ent_q[i].addr == push_addr &&
                !(pop_en && PW'(i) == head_q)) begin
                mrg_hit = 1'b1;
                mrg_idx = PW'(i);
            end
        end
    end

    assign new_alloc = push_en && !mrg_hit;

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) ent_q[i] <= '0;
            head_q <= '0;
            tail_q <= '0;
            cnt_q  <= '0;
        end else begin
            if (pop_en) begin
                ent_q[head_q].vld <= 1'b0;
                head_q <= head_q + 1'b1;
            end
            if (push_en && mrg_hit)
                ent_q[mrg_idx].data <= push_data;
            if (new_alloc) begin
                ent_q[tail_q] <= '{vld: 1'b1, addr: push_addr, data: push_data};
                tail_q <= tail_q + 1'b1;
            end
            cnt_q <= cnt_q + CW'(new_alloc) - CW'(pop_en);
        end
    end

    assign head_addr = ent_q[head_q].addr;
    assign head_data = ent_q[head_q].data;
    assign count     = cnt_q;

    // R9
    no_overflow_chk: assert property (@(posedge clk) disable iff (rst)
        cnt_q <= CW'(DEPTH));
    // R9
    alloc_room_chk: assert property (@(posedge clk) disable iff (rst)
        new_alloc |-> cnt_q < CW'(DEPTH));
    // R7
    pop_nonempty_chk: assert property (@(posedge clk) disable iff (rst)
        pop_en |-> ent_q[head_q].vld);
endmodule

// File: rtl/wdb_arb.sv
module wdb_arb
    import wdb_pkg::*;
#(
    parameter int CW        = 4,
    parameter int DRAIN_THR = 6
) (
    input  logic          rd_valid,
    input  logic          rd_hit,
    input  logic [CW-1:0] count,
    input  logic          cmd_ready,
    output cmd_sel_e      sel,
    output logic          rd_take,
    output logic          pop
);
    logic drain_force;

    assign drain_force = count >= CW'(DRAIN_THR);

    always_comb begin
        sel = SEL_NONE;
        if (drain_force)
            sel = SEL_WRITE;
        else if (rd_valid && !rd_hit)
            sel = SEL_READ;
        else if (count != '0)
            sel = SEL_WRITE;
    end

    assign rd_take = rd_hit || (sel == SEL_READ && cmd_ready);
    assign pop     = (sel == SEL_WRITE) && cmd_ready;
endmodule

// File: rtl/wdefer_buf.sv
module wdefer_buf
    import wdb_pkg::*;
#(
    parameter int DEPTH     = 8,
    parameter int DRAIN_THR = 6,
    localparam int CW = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              rd_valid,
    output logic              rd_ready,
    input  logic [ADDR_W-1:0] rd_addr,
    input  logic              wr_valid,
    output logic              wr_ready,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    output logic              cmd_valid,
    input  logic              cmd_ready,
    output logic              cmd_we,
    output logic [ADDR_W-1:0] cmd_addr,
    output logic [DATA_W-1:0] cmd_data,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_data
);
    logic              push_en, pop_en, rd_hit;
    logic [DATA_W-1:0] hit_data, head_data;
    logic [ADDR_W-1:0] head_addr;
    logic [CW-1:0]     cnt;
    cmd_sel_e          sel;
    logic              rsp_valid_q;
    logic [DATA_W-1:0] rsp_data_q;

    assign wr_ready = cnt < CW'(DEPTH);
    assign push_en  = wr_valid && wr_ready;

    wdb_store #(.DEPTH(DEPTH)) u_store (
        .clk       (clk),
        .rst       (rst),
        .push_en   (push_en),
        .push_addr (wr_addr),
        .push_data (wr_data),
        .pop_en    (pop_en),
        .look_addr (rd_addr),
        .look_hit  (rd_hit),
        .look_data (hit_data),
        .head_addr (head_addr),
        .head_data (head_data),
        .count     (cnt)
    );

    wdb_arb #(.CW(CW), .DRAIN_THR(DRAIN_THR)) u_arb (
        .rd_valid  (rd_valid),
        .rd_hit    (rd_hit),
        .count     (cnt),
        .cmd_ready (cmd_ready),
        .sel       (sel),
        .rd_take   (rd_ready),
        .pop       (pop_en)
    );

    assign cmd_valid = sel != SEL_NONE;
    assign cmd_we    = sel == SEL_WRITE;
    assign cmd_addr  = (sel == SEL_WRITE) ? head_addr : rd_addr;
    assign cmd_data  = (sel == SEL_WRITE) ? head_data : '0;

    // store contents are read before this cycle's write lands (R5)
    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_valid_q <= 1'b0;
            rsp_data_q  <= '0;
        end else begin
            rsp_valid_q <= rd_valid && rd_hit;
            rsp_data_q  <= hit_data;
        end
    end

    assign rsp_valid = rsp_valid_q;
    assign rsp_data  = rsp_data_q;

    // R4
    hit_resp_chk: assert property (@(posedge clk) disable iff (rst)
        rd_valid && rd_hit |=> rsp_valid);
    // R4
    hit_no_rdcmd_chk: assert property (@(posedge clk) disable iff (rst)
        rd_valid && rd_hit |-> !(cmd_valid && !cmd_we));
    // R3
    miss_issue_chk: assert property (@(posedge clk) disable iff (rst)
        rd_valid && !rd_hit && cnt < CW'(DRAIN_THR)
        |-> cmd_valid && !cmd_we && cmd_addr == rd_addr);
    // R8
    thr_drain_chk: assert property (@(posedge clk) disable iff (rst)
        cnt >= CW'(DRAIN_THR) |-> cmd_valid && cmd_we && !(rd_valid && !rd_hit && rd_ready));
    // R2
    wr_hold_chk: assert property (@(posedge clk) disable iff (rst)
        $past(cnt == '0) && cnt == '0 |-> !(cmd_valid && cmd_we));
endmodule

// File: tb/wdefer_buf_tb.sv
module wdefer_buf_tb;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        rd_valid = 1'b0, wr_valid = 1'b0, cmd_ready = 1'b0;
    logic [15:0] rd_addr = '0, wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic        rd_ready, wr_ready, cmd_valid, cmd_we, rsp_valid;
    logic [15:0] cmd_addr;
    logic [31:0] cmd_data, rsp_data;

    int n_chk = 0, n_fail = 0;
    bit done = 0;
    logic [31:0] exp_q[$];
    logic [31:0] shadow [int];
    logic [31:0] mem [int];

    always #2 clk = ~clk;

    wdefer_buf u_dut (
        .clk(clk), .rst(rst),
        .rd_valid(rd_valid), .rd_ready(rd_ready), .rd_addr(rd_addr),
        .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_addr(wr_addr), .wr_data(wr_data),
        .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_we(cmd_we),
        .cmd_addr(cmd_addr), .cmd_data(cmd_data),
        .rsp_valid(rsp_valid), .rsp_data(rsp_data)
    );

    task automatic chk(bit ok, string req, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] rd_map(ref logic [31:0] m [int], input int a);
        return m.exists(a) ? m[a] : 32'h0;
    endfunction

    task automatic tick(); @(posedge clk); #1; endtask
    task automatic smp();  @(negedge clk); endtask

    task automatic finish_all();
        if (!done) begin
            done = 1;
            $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    endtask

    // scoreboard monitor: read handshakes push the expected value, responses pop it
    always @(negedge clk) begin
        if (!rst) begin
            if (rsp_valid) begin
                if (exp_q.size() == 0) chk(0, "R10 spurious rsp", rsp_data, 0);
                else begin
                    logic [31:0] e;
                    e = exp_q.pop_front();
                    chk(rsp_data == e, "R10 hit data", rsp_data, e);
                end
            end
            if (rd_valid && rd_ready) begin
                logic [31:0] e;
                e = rd_map(shadow, int'(rd_addr));
                if (cmd_valid && cmd_ready && !cmd_we)
                    chk(rd_map(mem, int'(rd_addr)) == e, "R10 miss data",
                        rd_map(mem, int'(rd_addr)), e);
                else
                    exp_q.push_back(e);
            end
            if (cmd_valid && cmd_ready && cmd_we) mem[int'(cmd_addr)] = cmd_data;
            if (wr_valid && wr_ready) shadow[int'(wr_addr)] = wr_data;
        end
    end

    initial begin
        #(4 * 150000);
        chk(0, "watchdog", 0, 1);
        finish_all();
    end

    task automatic wr(input logic [15:0] a, input logic [31:0] d);
        wr_valid = 1; wr_addr = a; wr_data = d;
        smp();
        tick();
        wr_valid = 0;
    endtask

    initial begin
        logic [15:0] seen_a [16];
        logic [31:0] seen_d [16];
        int n;
        bit rd_acc, wr_acc;

        repeat (4) tick();
        rst = 0;
        smp();
        // R1
        chk(!cmd_valid, "R1 cmd_valid", cmd_valid, 0);
        chk(!rsp_valid, "R1 rsp_valid", rsp_valid, 0);
        chk(wr_ready, "R1 wr_ready", wr_ready, 1);
        tick();

        // R2: write held, appears only the next cycle
        wr_valid = 1; wr_addr = 16'h10; wr_data = 32'h111;
        smp();
        chk(!cmd_valid, "R2 same-cycle issue", cmd_valid, 0);
        tick();
        wr_valid = 0;
        smp();
        chk(cmd_valid && cmd_we && cmd_addr == 16'h10, "R2 later issue", cmd_addr, 16'h10);
        tick();

        // R4: read hit served locally
        rd_valid = 1; rd_addr = 16'h10;
        smp();
        chk(rd_ready, "R4 hit accept", rd_ready, 1);
        chk(!(cmd_valid && !cmd_we), "R4 no read cmd", cmd_we, 1);
        tick();
        rd_valid = 0;
        smp();
        chk(rsp_valid && rsp_data == 32'h111, "R4 hit rsp", rsp_data, 32'h111);
        tick();

        // R6: merge then youngest data
        wr(16'h10, 32'h222);
        wr(16'h20, 32'h333);
        rd_valid = 1; rd_addr = 16'h10;
        smp(); tick();
        rd_valid = 0;
        smp();
        chk(rsp_valid && rsp_data == 32'h222, "R6 merged data", rsp_data, 32'h222);
        tick();
        cmd_ready = 1; n = 0;
        for (int c = 0; c < 5; c++) begin
            smp();
            if (cmd_valid && cmd_we && n < 16) begin seen_a[n] = cmd_addr; seen_d[n] = cmd_data; n++; end
            tick();
        end
        chk(n == 2, "R6 entry count", n, 2);
        chk(seen_a[0] == 16'h10 && seen_d[0] == 32'h222, "R7 first drain", seen_d[0], 32'h222);
        chk(seen_a[1] == 16'h20 && seen_d[1] == 32'h333, "R7 second drain", seen_d[1], 32'h333);

        // R5: same-cycle write does not serve the read
        wr_valid = 1; wr_addr = 16'h30; wr_data = 32'h444;
        rd_valid = 1; rd_addr = 16'h30;
        smp();
        chk(cmd_valid && !cmd_we && cmd_addr == 16'h30 && rd_ready, "R5 read goes down", cmd_we, 0);
        tick();
        wr_valid = 0; rd_valid = 0;
        repeat (3) tick();
        cmd_ready = 0;

        // R3: read miss overtakes held writes
        for (int i = 0; i < 3; i++) wr(16'h40 + 16'(i), 32'h500 + 32'(i));
        rd_valid = 1; rd_addr = 16'h50; cmd_ready = 1;
        smp();
        chk(cmd_valid && !cmd_we && cmd_addr == 16'h50 && rd_ready, "R3 read first", cmd_addr, 16'h50);
        tick();
        rd_valid = 0; cmd_ready = 0;

        // R8: threshold forces drain
        for (int i = 3; i < 6; i++) wr(16'h40 + 16'(i), 32'h500 + 32'(i));
        rd_valid = 1; rd_addr = 16'h51;
        smp();
        chk(cmd_valid && cmd_we && cmd_addr == 16'h40, "R8 write wins", cmd_addr, 16'h40);
        chk(!rd_ready, "R8 read waits", rd_ready, 0);
        tick();
        rd_valid = 0;

        // R9: full
        for (int i = 6; i < 8; i++) wr(16'h40 + 16'(i), 32'h500 + 32'(i));
        smp();
        chk(!wr_ready, "R9 full stall", wr_ready, 0);
        tick();
        cmd_ready = 1; n = 0;
        for (int c = 0; c < 11; c++) begin
            smp();
            if (cmd_valid && cmd_we && n < 16) begin seen_a[n] = cmd_addr; seen_d[n] = cmd_data; n++; end
            tick();
        end
        chk(n == 8, "R7 drain count", n, 8);
        for (int i = 0; i < 8; i++)
            chk(seen_a[i] == 16'h40 + 16'(i), "R7 drain order", seen_a[i], 16'h40 + 16'(i));

        // random traffic, scoreboard covers R10
        rd_acc = 1; wr_acc = 1;
        for (int c = 0; c < 3000; c++) begin
            if (!rd_valid || rd_acc) begin
                rd_valid = ($urandom % 3) == 0; rd_addr = 16'($urandom % 8);
            end
            if (!wr_valid || wr_acc) begin
                wr_valid = ($urandom % 2) == 0; wr_addr = 16'($urandom % 8); wr_data = $urandom;
            end
            cmd_ready = ($urandom % 4) != 0;
            smp();
            rd_acc = rd_valid && rd_ready;
            wr_acc = wr_valid && wr_ready;
            tick();
        end
        rd_valid = 0; wr_valid = 0; cmd_ready = 1;
        repeat (12) tick();
        smp();
        chk(!cmd_valid, "R7 drained empty", cmd_valid, 0);
        chk(exp_q.size() == 0, "R10 all responses", exp_q.size(), 0);
        finish_all();
    end
endmodule